// File: doc/BRIEF.md
# Serial ADC Sampling Controller

This block is the host-side sequencer for a 16-bit serial sampling converter. The converter has a convert strobe and a three-wire shift port. Everything runs on the system clock. Each interface interval is a count of system clock cycles, and a counter enforces it.

A conversion request comes from a trigger pin or from an internal sample-rate timer. The controller then runs one cycle:
- It drops the convert line for an acquisition window.
- It raises the convert line for the conversion time.
- It lowers the convert line again and clocks out 16 result bits, most significant bit first, sampling each bit as the shift clock rises.
- During that same readout it sends a two-bit channel-selection word on the data-in line. The converter applies this word to the *next* conversion.

Because the selection takes effect one conversion late, each result is tagged with the selection sent during the previous readout. The first result after reset is flagged as having an unknown channel.

Results leave on a valid/ready stream. A result is held with valid high until ready is seen. While a result is waiting, no new conversion cycle starts. Requests that arrive while the controller is busy are not queued.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After synchronous reset the convert line is high, the shift clock is low and result valid is low.
- R2: A started cycle drives the convert line low for exactly ACQ_CYC cycles, then high for exactly CONV_CYC cycles, then low for the readout.
- R3: The shift clock is low whenever the convert line is high. The first shift-clock rise comes at least SETUP_CYC cycles after the convert line falls. The convert line rises at least HOLD_CYC cycles after the last shift-clock fall.
- R4: Each readout has exactly 16 shift-clock pulses. Every high phase lasts SCK_HALF cycles, and every low phase between two pulses lasts SCK_HALF cycles.
- R5: The result word is assembled from the data-out line sampled at each shift-clock rise, most significant bit first.
- R6: On the data-in line, the selection bit 1 (single-ended when 1) is present at the first shift-clock rise and bit 0 (odd/sign) at the second. The line is 0 at every later rise and changes only while the shift clock is low. The selection is latched when the cycle starts. The four codes mean:
  - 10: channel 0 against ground
  - 11: channel 1 against ground
  - 00: channel 0 positive, channel 1 negative
  - 01: channel 0 negative, channel 1 positive
- R7: Each result carries as its tag the selection sent during the previous readout. The first result after reset has the unknown-tag flag set to 1, and all later results have it set to 0.
- R8: While valid is high and ready is low, valid, data and tag stay unchanged, and no new cycle starts even if the trigger is held.
- R9: With the timer enabled and nothing blocking, cycles start every RATE_CYC cycles.
- R10: Two cycle starts are never closer than MIN_PERIOD cycles. A trigger held high starts cycles exactly MIN_PERIOD apart when nothing else blocks.
- R11: A trigger pulse that arrives while a cycle is in progress is dropped and does not start a later cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| trig_i | input | 1 | Conversion request, sampled only when idle |
| auto_en_i | input | 1 | Enables the internal sample-rate timer |
| chan_sel_i | input | CFG_BITS | Selection word sent during the next readout |
| cnv_o | output | 1 | Convert line to the converter |
| sck_o | output | 1 | Shift clock to the converter |
| sdi_o | output | 1 | Selection data to the converter |
| sdo_i | input | 1 | Result data from the converter |
| res_valid_o | output | 1 | Result stream valid |
| res_ready_i | input | 1 | Result stream ready |
| res_data_o | output | RES_BITS | Result word |
| res_tag_o | output | CFG_BITS | Selection in force for this result |
| res_tag_unknown_o | output | 1 | Tag is not known (first result after reset) |

## Verification
The bench builds the block with these parameter values:

| Parameter | Value |
|---|---|
| SCK_HALF | 2 |
| ACQ_CYC | 4 |
| CONV_CYC | 10 |
| SETUP_CYC | 2 |
| HOLD_CYC | 2 |
| MIN_PERIOD | 120 |
| RATE_CYC | 150 |

With these values a whole conversion cycle takes about 85 cycles, so many cycles fit in a short run. Because MIN_PERIOD is longer than a cycle, a held trigger exposes the spacing floor exactly. Because RATE_CYC is longer again, the timer period can be measured on its own. A behavioural converter model in the bench returns words that embed the selection it latched, so tag ordering, selection capture and the bit order of the result are all checked together.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACQ,
    ST_CONV,
    ST_SETUP,
    ST_SHIFT,
    ST_HOLD
  } seq_state_e;

  // Selection word codes (bit 1 = single-ended, bit 0 = odd/sign)
  localparam logic [1:0] SEL_CH0_GND  = 2'b10;
  localparam logic [1:0] SEL_CH1_GND  = 2'b11;
  localparam logic [1:0] SEL_DIFF_0P  = 2'b00;
  localparam logic [1:0] SEL_DIFF_1P  = 2'b01;

  function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                       input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/adc_rate_timer.sv
module adc_rate_timer #(
  parameter int unsigned RATE_CYC   = 1000,
  parameter int unsigned MIN_PERIOD = 667
) (
  input  logic clk,
  input  logic rst,
  input  logic auto_en_i,
  input  logic start_i,
  output logic tick_pend_o,
  output logic gap_ok_o
);
  localparam int RW = $clog2(RATE_CYC + 1);
  localparam int GW = $clog2(MIN_PERIOD + 1);
  localparam logic [RW-1:0] R_LAST = RW'(RATE_CYC - 1);
  localparam logic [GW-1:0] G_FULL = GW'(MIN_PERIOD);

  logic [RW-1:0] rcnt;
  logic          pend;
  logic [GW-1:0] gap;

  // Free-running sample-rate timer; a tick stays pending until a cycle starts
  always_ff @(posedge clk) begin
    if (rst || !auto_en_i) begin
      rcnt <= '0;
      pend <= 1'b0;
    end else begin
      if (rcnt == R_LAST) begin
        rcnt <= '0;
        pend <= 1'b1;
      end else begin
        rcnt <= rcnt + 1'b1;
        if (start_i) pend <= 1'b0;
      end
    end
  end

  // Cycles since the last start, saturating at the minimum spacing
  always_ff @(posedge clk) begin
    if (rst) begin
      gap <= G_FULL;
    end else if (start_i) begin
      gap <= GW'(1);
    end else if (gap != G_FULL) begin
      gap <= gap + 1'b1;
    end
  end

  assign tick_pend_o = pend;
  assign gap_ok_o    = (gap == G_FULL);

  // R9: timer expiry with the timer enabled leaves a pending tick
  a_r9_tick_on_expiry: assert property (@(posedge clk) disable iff (rst)
    (auto_en_i && rcnt == R_LAST) |=> tick_pend_o);

  // R10: a start is refused until the spacing window has elapsed
  a_r10_gap_closed: assert property (@(posedge clk) disable iff (rst)
    start_i |=> !gap_ok_o);

endmodule

// File: rtl/adc_shift_eng.sv
module adc_shift_eng #(
  parameter int unsigned RES_BITS = 16,
  parameter int unsigned CFG_BITS = 2,
  parameter int unsigned SCK_HALF = 7
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                go_i,
  input  logic [CFG_BITS-1:0] cfg_i,
  input  logic                sdo_i,
  output logic                sck_o,
  output logic                sdi_o,
  output logic                done_o,
  output logic [RES_BITS-1:0] data_o
);
  localparam int BW = $clog2(RES_BITS);
  localparam int HW = $clog2(SCK_HALF + 1);
  localparam logic [BW-1:0] BIT_LAST = BW'(RES_BITS - 1);
  localparam logic [HW-1:0] PH_LAST  = HW'(SCK_HALF - 1);

  logic                active;
  logic                hi;
  logic [HW-1:0]       ph;
  logic [BW-1:0]       bitc;
  logic [RES_BITS-1:0] shreg;
  logic                done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      hi     <= 1'b0;
      ph     <= '0;
      bitc   <= '0;
      shreg  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (go_i) begin
        active <= 1'b1;
        hi     <= 1'b0;
        ph     <= '0;
        bitc   <= '0;
      end else if (active) begin
        if (ph == PH_LAST) begin
          ph <= '0;
          if (!hi) begin
            // rising edge: take the bit the converter drove on the last fall
            hi    <= 1'b1;
            shreg <= {shreg[RES_BITS-2:0], sdo_i};
          end else begin
            hi <= 1'b0;
            if (bitc == BIT_LAST) begin
              active <= 1'b0;
              bitc   <= '0;
              done_q <= 1'b1;
            end else begin
              bitc <= bitc + 1'b1;
            end
          end
        end else begin
          ph <= ph + 1'b1;
        end
      end
    end
  end

  // Selection bits lead the data-in stream, zeros after; advances on falls
  always_comb begin
    sdi_o = 1'b0;
    for (int i = 0; i < int'(CFG_BITS); i++) begin
      if (bitc == BW'(i)) sdi_o = cfg_i[CFG_BITS-1-i];
    end
  end

  assign sck_o  = hi;
  assign done_o = done_q;
  assign data_o = shreg;

  // checker: length of the current high phase
  int unsigned hi_run;
  always_ff @(posedge clk) begin
    if (rst)        hi_run <= 0;
    else if (sck_o) hi_run <= hi_run + 1;
    else            hi_run <= 0;
  end

  // R4: every high phase is SCK_HALF cycles long
  a_r4_high_width: assert property (@(posedge clk) disable iff (rst)
    $fell(sck_o) |-> (hi_run == SCK_HALF));

  // R6: data-in holds steady while the shift clock is high
  a_r6_sdi_steady: assert property (@(posedge clk) disable iff (rst)
    sck_o |-> $stable(sdi_o));

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int unsigned RES_BITS   = 16,
  parameter int unsigned CFG_BITS   = 2,
  parameter bit          TWO_CH     = 1'b1,
  parameter int unsigned SCK_HALF   = 7,
  parameter int unsigned ACQ_CYC    = 64,
  parameter int unsigned CONV_CYC   = 470,
  parameter int unsigned SETUP_CYC  = 6,
  parameter int unsigned HOLD_CYC   = 3,
  parameter int unsigned MIN_PERIOD = 667,
  parameter int unsigned RATE_CYC   = 1000
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                trig_i,
  input  logic                auto_en_i,
  input  logic [CFG_BITS-1:0] chan_sel_i,
  output logic                cnv_o,
  output logic                sck_o,
  output logic                sdi_o,
  input  logic                sdo_i,
  output logic                res_valid_o,
  input  logic                res_ready_i,
  output logic [RES_BITS-1:0] res_data_o,
  output logic [CFG_BITS-1:0] res_tag_o,
  output logic                res_tag_unknown_o
);
  localparam int unsigned PH_MAX = max4(ACQ_CYC, CONV_CYC, SETUP_CYC, HOLD_CYC);
  localparam int CNT_W = $clog2(PH_MAX + 1);
  localparam logic [CNT_W-1:0] ACQ_LAST   = CNT_W'(ACQ_CYC - 1);
  localparam logic [CNT_W-1:0] CONV_LAST  = CNT_W'(CONV_CYC - 1);
  localparam logic [CNT_W-1:0] SETUP_LAST = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] HOLD_LAST  = CNT_W'(HOLD_CYC - 1);

  seq_state_e          state;
  logic [CNT_W-1:0]    cnt;
  logic                cnv_q;
  logic [CFG_BITS-1:0] cfg_q;

  logic                tick_pend, gap_ok, start_go, eng_go, eng_done, eng_sdi, hold_end;
  logic [RES_BITS-1:0] eng_data;
  logic [CFG_BITS-1:0] tag_next;
  logic                unk_next;

  logic                valid_q, unk_q;
  logic [RES_BITS-1:0] data_q;
  logic [CFG_BITS-1:0] tag_q;

  assign start_go = (state == ST_IDLE) && !valid_q && gap_ok && (trig_i || tick_pend);
  assign eng_go   = (state == ST_SETUP) && (cnt == SETUP_LAST);
  assign hold_end = (state == ST_HOLD) && (cnt == HOLD_LAST);

  adc_rate_timer #(.RATE_CYC(RATE_CYC), .MIN_PERIOD(MIN_PERIOD)) u_timer (
    .clk(clk), .rst(rst), .auto_en_i(auto_en_i), .start_i(start_go),
    .tick_pend_o(tick_pend), .gap_ok_o(gap_ok)
  );

  adc_shift_eng #(.RES_BITS(RES_BITS), .CFG_BITS(CFG_BITS), .SCK_HALF(SCK_HALF)) u_shift (
    .clk(clk), .rst(rst), .go_i(eng_go), .cfg_i(cfg_q), .sdo_i(sdo_i),
    .sck_o(sck_o), .sdi_o(eng_sdi), .done_o(eng_done), .data_o(eng_data)
  );

  // Convert-line sequencer
  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
      cnv_q <= 1'b1;
      cfg_q <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start_go) begin
          state <= ST_ACQ;
          cnt   <= '0;
          cnv_q <= 1'b0;
          cfg_q <= chan_sel_i;
        end
        ST_ACQ: if (cnt == ACQ_LAST) begin
          state <= ST_CONV;
          cnt   <= '0;
          cnv_q <= 1'b1;
        end else cnt <= cnt + 1'b1;
        ST_CONV: if (cnt == CONV_LAST) begin
          state <= ST_SETUP;
          cnt   <= '0;
          cnv_q <= 1'b0;
        end else cnt <= cnt + 1'b1;
        ST_SETUP: if (eng_go) begin
          state <= ST_SHIFT;
          cnt   <= '0;
        end else cnt <= cnt + 1'b1;
        ST_SHIFT: if (eng_done) begin
          state <= ST_HOLD;
          cnt   <= '0;
        end
        ST_HOLD: if (hold_end) begin
          state <= ST_IDLE;
          cnt   <= '0;
          cnv_q <= 1'b1;
        end else cnt <= cnt + 1'b1;
        default: begin
          state <= ST_IDLE;
          cnv_q <= 1'b1;
        end
      endcase
    end
  end

  // Channel tagging variant
  generate
    if (TWO_CH) begin : g_dual
      logic [CFG_BITS-1:0] prev_sel;
      logic                prev_known;
      always_ff @(posedge clk) begin
        if (rst) begin
          prev_sel   <= '0;
          prev_known <= 1'b0;
        end else if (hold_end) begin
          prev_sel   <= cfg_q;
          prev_known <= 1'b1;
        end
      end
      assign tag_next = prev_sel;
      assign unk_next = !prev_known;
      assign sdi_o    = eng_sdi;
    end else begin : g_single
      assign tag_next = '0;
      assign unk_next = 1'b0;
      assign sdi_o    = 1'b0;
    end
  endgenerate

  // Result stream register
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      data_q  <= '0;
      tag_q   <= '0;
      unk_q   <= 1'b0;
    end else if (hold_end) begin
      valid_q <= 1'b1;
      data_q  <= eng_data;
      tag_q   <= tag_next;
      unk_q   <= unk_next;
    end else if (valid_q && res_ready_i) begin
      valid_q <= 1'b0;
    end
  end

  assign cnv_o             = cnv_q;
  assign res_valid_o       = valid_q;
  assign res_data_o        = data_q;
  assign res_tag_o         = tag_q;
  assign res_tag_unknown_o = unk_q;

  // checker: spacing between cycle starts seen on the convert line
  logic        cnv_d;
  seq_state_e  st_d;
  int unsigned since_start;
  logic        start_seen;
  assign start_seen = cnv_d && !cnv_o && (st_d == ST_IDLE);
  always_ff @(posedge clk) begin
    if (rst) begin
      cnv_d       <= 1'b1;
      st_d        <= ST_IDLE;
      since_start <= MIN_PERIOD;
    end else begin
      cnv_d <= cnv_o;
      st_d  <= state;
      if (start_seen)                    since_start <= 1;
      else if (since_start < MIN_PERIOD) since_start <= since_start + 1;
    end
  end

  // R1: reset leaves the interface quiet
  a_r1_reset_state: assert property (@(posedge clk)
    $past(rst) |-> (cnv_o && !sck_o && !res_valid_o));

  // R3: no shift clock while the convert line is high
  a_r3_sck_low_when_cnv: assert property (@(posedge clk) disable iff (rst)
    cnv_o |-> !sck_o);

  // R8: a stalled result holds still
  a_r8_hold_result: assert property (@(posedge clk) disable iff (rst)
    (res_valid_o && !res_ready_i) |=>
      (res_valid_o && $stable(res_data_o) && $stable(res_tag_o) && $stable(res_tag_unknown_o)));

  // R8: no cycle leaves idle while a result is pending
  a_r8_no_start_pending: assert property (@(posedge clk) disable iff (rst)
    (res_valid_o && state == ST_IDLE) |=> cnv_o);

  // R10: starts are at least MIN_PERIOD apart
  a_r10_spacing: assert property (@(posedge clk) disable iff (rst)
    start_seen |-> (since_start >= MIN_PERIOD));

endmodule

// File: tb/adc_seq_ctrl_bench.sv
module adc_seq_ctrl_bench;
  localparam int SCK_HALF   = 2;
  localparam int ACQ_CYC    = 4;
  localparam int CONV_CYC   = 10;
  localparam int SETUP_CYC  = 2;
  localparam int HOLD_CYC   = 2;
  localparam int MIN_PERIOD = 120;
  localparam int RATE_CYC   = 150;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic trig = 1'b0, auto_en = 1'b0, rdy = 1'b1, sdo_b = 1'b0;
  logic [1:0] sel = 2'b00;
  logic cnv, sck, sdi, vld, unk;
  logic [15:0] dat;
  logic [1:0] tag;

  always #10 clk = ~clk;

  adc_seq_ctrl #(
    .RES_BITS(16), .CFG_BITS(2), .TWO_CH(1'b1), .SCK_HALF(SCK_HALF),
    .ACQ_CYC(ACQ_CYC), .CONV_CYC(CONV_CYC), .SETUP_CYC(SETUP_CYC),
    .HOLD_CYC(HOLD_CYC), .MIN_PERIOD(MIN_PERIOD), .RATE_CYC(RATE_CYC)
  ) u_adc_seq_ctrl (
    .clk(clk), .rst(rst), .trig_i(trig), .auto_en_i(auto_en), .chan_sel_i(sel),
    .cnv_o(cnv), .sck_o(sck), .sdi_o(sdi), .sdo_i(sdo_b),
    .res_valid_o(vld), .res_ready_i(rdy), .res_data_o(dat),
    .res_tag_o(tag), .res_tag_unknown_o(unk)
  );

  typedef struct { logic [15:0] d; logic [1:0] t; logic u; } exp_t;
  exp_t q[$];

  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // bench state shared between driver and monitor
  logic [13:0] pattern = '0;
  logic [1:0]  sent_cfg = 2'b00;
  logic [1:0]  exp_prev = 2'b10;   // converter model powers up on 10
  bit          exp_known = 1'b0;
  int          exp_gap = 0;
  string       gap_req = "R10";
  int          starts = 0;

  // converter model + interface timing monitor + scoreboard
  logic [15:0] dev_word = '0;
  logic [1:0]  dev_mux = 2'b10;
  logic [1:0]  cap = '0;
  logic        p_cnv = 1'b1, p_sck = 1'b0;
  int cyc = 0, fall_n = 0, last_start = -1, acq_t = 0, conv_t = 0, rd_t = 0;
  int pulses = 0, bit_idx = 0, last_rise = 0, last_fall = 0;

  always @(negedge clk) begin
    if (!rst) begin
      cyc++;
      if (cnv != p_cnv) begin
        if (!cnv) begin
          fall_n++;
          if (fall_n % 2 == 1) begin
            starts++;
            if (last_start >= 0) begin
              chk(cyc - last_start >= MIN_PERIOD, "R10 spacing floor", cyc - last_start, MIN_PERIOD);
              if (exp_gap != 0) chk(cyc - last_start == exp_gap, gap_req, cyc - last_start, exp_gap);
            end
            last_start = cyc;
            acq_t = cyc;
          end else begin
            chk(cyc - conv_t == CONV_CYC, "R2 conversion high time", cyc - conv_t, CONV_CYC);
            rd_t = cyc; pulses = 0; bit_idx = 0;
            sdo_b = dev_word[15];
          end
        end else begin
          if (fall_n % 2 == 1) begin
            chk(cyc - acq_t == ACQ_CYC, "R2 acquisition low time", cyc - acq_t, ACQ_CYC);
            conv_t = cyc;
            dev_word = {dev_mux, pattern};
          end else begin
            chk(pulses == 16, "R4 pulse count", pulses, 16);
            chk(cyc - last_fall >= HOLD_CYC, "R3 hold after last fall", cyc - last_fall, HOLD_CYC);
          end
        end
      end
      if (sck && !p_sck) begin
        chk(!cnv, "R3 sck only with cnv low", cnv, 0);
        if (pulses == 0) chk(cyc - rd_t >= SETUP_CYC, "R3 setup before first rise", cyc - rd_t, SETUP_CYC);
        else             chk(cyc - last_fall == SCK_HALF, "R4 low width", cyc - last_fall, SCK_HALF);
        pulses++;
        if (bit_idx < 2) cap = {cap[0], sdi};
        else             chk(sdi == 1'b0, "R6 data-in zero after selection", sdi, 0);
        last_rise = cyc;
      end
      if (!sck && p_sck) begin
        chk(cyc - last_rise == SCK_HALF, "R4 high width", cyc - last_rise, SCK_HALF);
        bit_idx++;
        sdo_b = (bit_idx < 16) ? dev_word[15 - bit_idx] : 1'b0;
        if (bit_idx == 2) begin
          chk(cap == sent_cfg, "R6 selection word order", cap, sent_cfg);
          dev_mux = cap;
        end
        last_fall = cyc;
      end
      if (vld && rdy) begin
        if (q.size() == 0) begin
          chk(1'b0, "R8 unexpected result", dat, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(dat == e.d, "R5 result word", dat, e.d);
          chk(unk == e.u, "R7 unknown flag", unk, e.u);
          if (!e.u) chk(tag == e.t, "R7 tag", tag, e.t);
        end
      end
      p_cnv = cnv;
      p_sck = sck;
    end
  end

  task automatic push_exp(input logic [1:0] cfg, input logic [13:0] pat);
    exp_t e;
    e.d = {exp_prev, pat}; e.t = exp_prev; e.u = !exp_known;
    q.push_back(e);
    exp_prev = cfg; exp_known = 1'b1;
  endtask

  task automatic wait_start(input int s0);
    while (starts == s0) @(negedge clk);
  endtask

  task automatic wait_drain();
    while (q.size() > 0) @(negedge clk);
  endtask

  task automatic one_cycle(input logic [1:0] cfg, input logic [13:0] pat);
    int s0;
    @(negedge clk);
    sel = cfg; sent_cfg = cfg; pattern = pat;
    push_exp(cfg, pat);
    s0 = starts;
    trig = 1'b1;
    wait_start(s0);
    trig = 1'b0;
    wait_drain();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin : driver
    int s0;
    logic [15:0] held_d;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(cnv == 1'b1, "R1 convert line high", cnv, 1);
    chk(sck == 1'b0, "R1 shift clock low", sck, 0);
    chk(vld == 1'b0, "R1 valid low", vld, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    // R6 / R7 / R5: all four selection codes, varied data patterns
    one_cycle(2'b10, 14'h1A5C);
    one_cycle(2'b11, 14'h2F01);
    one_cycle(2'b00, 14'h3FFF);
    one_cycle(2'b01, 14'h0000);
    one_cycle(2'b10, 14'h2AAA);

    // R11: trigger pulse during a busy cycle is dropped
    @(negedge clk);
    sel = 2'b11; sent_cfg = 2'b11; pattern = 14'h1555;
    push_exp(2'b11, 14'h1555);
    s0 = starts;
    trig = 1'b1;
    wait_start(s0);
    trig = 1'b0;
    repeat (20) @(negedge clk);
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
    wait_drain();
    s0 = starts;
    repeat (MIN_PERIOD + 40) @(negedge clk);
    chk(starts == s0, "R11 busy trigger dropped", starts, s0);

    // R8: back-pressure holds the result and blocks new cycles
    rdy = 1'b0;
    @(negedge clk);
    sel = 2'b00; sent_cfg = 2'b00; pattern = 14'h0F0F;
    push_exp(2'b00, 14'h0F0F);
    s0 = starts;
    trig = 1'b1;
    wait_start(s0);
    trig = 1'b0;
    while (!vld) @(negedge clk);
    held_d = dat;
    s0 = starts;
    trig = 1'b1;
    repeat (MIN_PERIOD + 40) @(negedge clk);
    chk(starts == s0, "R8 no start while pending", starts, s0);
    chk(vld == 1'b1, "R8 valid held", vld, 1);
    chk(dat == held_d, "R8 data held", dat, held_d);
    trig = 1'b0;
    @(negedge clk);
    rdy = 1'b1;
    wait_drain();

    // R10: held trigger runs at the spacing floor
    @(negedge clk);
    sel = 2'b01; sent_cfg = 2'b01; pattern = 14'h3C3C;
    for (int i = 0; i < 4; i++) push_exp(2'b01, 14'h3C3C);
    s0 = starts;
    trig = 1'b1;
    wait_start(s0);
    exp_gap = MIN_PERIOD; gap_req = "R10 held-trigger spacing";
    wait_drain();
    trig = 1'b0;
    exp_gap = 0;
    repeat (MIN_PERIOD + 10) @(negedge clk);

    // R9: internal timer paces the cycles
    for (int i = 0; i < 4; i++) push_exp(2'b01, 14'h3C3C);
    s0 = starts;
    auto_en = 1'b1;
    wait_start(s0);
    exp_gap = RATE_CYC; gap_req = "R9 timer spacing";
    wait_drain();
    auto_en = 1'b0;
    exp_gap = 0;
    s0 = starts;
    repeat (RATE_CYC + 20) @(negedge clk);
    chk(starts == s0, "R9 timer off stops cycles", starts, s0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule